// File: doc/BRIEF.md
# Macroblock Intra/Inter Mode Decider

This block chooses between INTRA and INTER coding for one 16x16 luminance macroblock. The 256 luma samples arrive as 8-bit values over a valid/ready handshake. The smallest full-pel SAD that motion search found for the macroblock is sampled together with the first pixel. While the samples arrive, the block sums them and writes each one into an internal buffer. The block mean is that sum shifted right by eight bits. A second pass then reads the buffer back and adds up the absolute distance of every sample from the mean. This gives an activity figure.

INTRA is chosen when the activity is strictly below the motion SAD less a fixed bias of 500. A set mode flag tells the encoder to skip half-pel refinement. A clear flag tells it to carry on with half-pel search. The flag, the mean and the activity are presented together with a one-cycle done pulse. They stay valid until the first pixel of the next macroblock is taken in.

Top module: `mode_decider`

## Requirements
- R1: While synchronous reset `rst` is high, and on the cycle after it, `pixReady` is 1, and `resValid` and `doneP` are 0.
- R2: A pixel is taken when `pixValid` and `pixReady` are both 1 at a rising clock edge. A macroblock is exactly 256 taken pixels. `sadIn` is sampled only on the edge that takes the first pixel of a macroblock.
- R3: After the 256th pixel is taken, `pixReady` is 0 for exactly 257 cycles, and `resValid` stays 0 in that time.
- R4: `meanOut` equals the sum of the 256 pixels shifted right by 8, truncating.
- R5: `actOut` (16 bits) equals the sum over all 256 pixels of |pixel - mean|, and it never exceeds 65280.
- R6: `intraMode` is 1 (INTRA, skip half-pel search) exactly when actOut < sadIn - 500, compared as signed integers. Otherwise it is 0 (INTER, run half-pel search). A SAD below 500 therefore always gives INTER.
- R7: `doneP` is high for one cycle, on the first cycle in which `resValid` is 1.
- R8: While `resValid` is 1, the mode flag, mean and activity hold steady. `resValid` falls on the cycle after the first pixel of the next macroblock is taken.
- R9: `pixValid` and `pixData` have no effect while `pixReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Pixel offered |
| pixReady | output | 1 | Block can take a pixel |
| pixData | input | 8 | Luma sample |
| sadIn | input | 16 | Minimum full-pel SAD, sampled with the first pixel |
| resValid | output | 1 | Decision outputs are valid |
| doneP | output | 1 | One-cycle pulse when a decision appears |
| intraMode | output | 1 | 1 = INTRA / skip half-pel, 0 = INTER / run half-pel |
| meanOut | output | 8 | Block mean |
| actOut | output | 16 | Sum of absolute deviations from the mean |

## Verification
The assertions check the following on every cycle:
- the stall length after the last pixel;
- that the done pulse lines up with the rising edge of valid;
- that the results hold steady while valid;
- the activity bound;
- that the mode flag matches the activity compared with the SAD captured with the first pixel.

The arithmetic of the mean and the activity can only be shown by the bench's scenarios:
- flat blocks;
- a ramp;
- a checkerboard;
- saturated and random blocks.

The scenarios also supply the equality edges of the bias comparison, the SAD values below the bias, and input noise during the stall.

// File: rtl/mode_decider_pkg.sv
package mode_decider_pkg;

  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_DEV    = 2'd1,
    PH_DECIDE = 2'd2,
    PH_SHOW   = 2'd3
  } phase_t;

  typedef struct packed {
    logic wrEn;
    logic firstPix;
    logic devEn;
    logic decideEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/mode_decider_ctrl.sv
module mode_decider_ctrl
  import mode_decider_pkg::*;
#(
  parameter int BLK_N = 256,
  localparam int IDX_W = $clog2(BLK_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  output logic             pixReady,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] idx,
  output logic             resValid,
  output logic             doneP
);

  phase_t phase;
  logic   accept;
  logic   lastIdx;

  always_comb begin
    pixReady          = (phase == PH_LOAD) || (phase == PH_SHOW);
    accept            = pixValid && pixReady;
    lastIdx           = (idx == IDX_W'(BLK_N - 1));
    strobes.wrEn      = accept;
    strobes.firstPix  = accept && (idx == '0);
    strobes.devEn     = (phase == PH_DEV);
    strobes.decideEn  = (phase == PH_DECIDE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_LOAD;
      idx      <= '0;
      resValid <= 1'b0;
      doneP    <= 1'b0;
    end else begin
      doneP <= 1'b0;
      unique case (phase)
        PH_LOAD, PH_SHOW: begin
          if (accept) begin
            resValid <= 1'b0;
            idx      <= lastIdx ? '0 : idx + 1'b1;
            phase    <= lastIdx ? PH_DEV : PH_LOAD;
          end
        end
        PH_DEV: begin
          idx <= lastIdx ? '0 : idx + 1'b1;
          if (lastIdx) phase <= PH_DECIDE;
        end
        PH_DECIDE: begin
          phase    <= PH_SHOW;
          resValid <= 1'b1;
          doneP    <= 1'b1;
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/mode_decider_dp.sv
module mode_decider_dp
  import mode_decider_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK_N = 256,
  parameter int SUM_W = 16,
  parameter int SAD_W = 16,
  parameter int BIAS  = 500,
  localparam int IDX_W = $clog2(BLK_N),
  localparam int CMP_W = ((SUM_W > SAD_W) ? SUM_W : SAD_W) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [IDX_W-1:0] idx,
  input  logic [PIX_W-1:0] pixData,
  input  logic [SAD_W-1:0] sadIn,
  output logic [PIX_W-1:0] meanOut,
  output logic [SUM_W-1:0] actOut,
  output logic             intraOut
);

  logic [PIX_W-1:0] pixMem [BLK_N];
  logic [SUM_W-1:0] sumAcc;
  logic [SUM_W-1:0] actAcc;
  logic [SAD_W-1:0] sadHold;
  logic [PIX_W-1:0] meanNow;
  logic [PIX_W-1:0] rdPix;
  logic [PIX_W-1:0] devAbs;
  logic signed [CMP_W-1:0] actSigned;
  logic signed [CMP_W-1:0] sadLessBias;
  logic intraNow;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) pixMem[idx] <= pixData;
  end

  always_comb begin
    meanNow     = sumAcc[IDX_W +: PIX_W];
    rdPix       = pixMem[idx];
    devAbs      = (rdPix >= meanNow) ? (rdPix - meanNow) : (meanNow - rdPix);
    actSigned   = $signed({{(CMP_W - SUM_W){1'b0}}, actAcc});
    sadLessBias = $signed({{(CMP_W - SAD_W){1'b0}}, sadHold}) - $signed(CMP_W'(BIAS));
    intraNow    = actSigned < sadLessBias;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumAcc   <= '0;
      actAcc   <= '0;
      sadHold  <= '0;
      meanOut  <= '0;
      actOut   <= '0;
      intraOut <= 1'b0;
    end else begin
      if (strobes.firstPix) begin
        sumAcc  <= SUM_W'(pixData);
        sadHold <= sadIn;
        actAcc  <= '0;
      end else if (strobes.wrEn) begin
        sumAcc <= sumAcc + SUM_W'(pixData);
      end
      if (strobes.devEn) actAcc <= actAcc + SUM_W'(devAbs);
      if (strobes.decideEn) begin
        meanOut  <= meanNow;
        actOut   <= actAcc;
        intraOut <= intraNow;
      end
    end
  end

endmodule

// File: rtl/mode_decider.sv
module mode_decider
  import mode_decider_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK_N = 256,
  parameter int SUM_W = 16,
  parameter int SAD_W = 16,
  parameter int BIAS  = 500,
  localparam int IDX_W = $clog2(BLK_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic [PIX_W-1:0] pixData,
  input  logic [SAD_W-1:0] sadIn,
  output logic             resValid,
  output logic             doneP,
  output logic             intraMode,
  output logic [PIX_W-1:0] meanOut,
  output logic [SUM_W-1:0] actOut
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] idx;

  mode_decider_ctrl #(.BLK_N(BLK_N)) ctrlU (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady),
    .strobes(strobes), .idx(idx), .resValid(resValid), .doneP(doneP)
  );

  mode_decider_dp #(
    .PIX_W(PIX_W), .BLK_N(BLK_N), .SUM_W(SUM_W), .SAD_W(SAD_W), .BIAS(BIAS)
  ) dpU (
    .clk(clk), .rst(rst), .strobes(strobes), .idx(idx), .pixData(pixData),
    .sadIn(sadIn), .meanOut(meanOut), .actOut(actOut), .intraOut(intraMode)
  );

endmodule

// File: rtl/mode_decider_checker.sv
module mode_decider_checker #(
  parameter int PIX_W = 8,
  parameter int BLK_N = 256,
  parameter int SUM_W = 16,
  parameter int SAD_W = 16,
  parameter int BIAS  = 500
) (
  input logic             clk,
  input logic             rst,
  input logic             pixValid,
  input logic             pixReady,
  input logic [PIX_W-1:0] pixData,
  input logic [SAD_W-1:0] sadIn,
  input logic             resValid,
  input logic             doneP,
  input logic             intraMode,
  input logic [PIX_W-1:0] meanOut,
  input logic [SUM_W-1:0] actOut
);

  int stallCnt;
  int takeCnt;
  logic [SAD_W-1:0] sadCap;
  logic take;

  assign take = pixValid && pixReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      stallCnt <= 0;
      takeCnt  <= 0;
      sadCap   <= '0;
    end else begin
      stallCnt <= pixReady ? 0 : stallCnt + 1;
      if (take) begin
        takeCnt <= (takeCnt == BLK_N - 1) ? 0 : takeCnt + 1;
        if (takeCnt == 0) sadCap <= sadIn;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pixReady && !resValid && !doneP));

  assert_stall_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pixReady) |-> (stallCnt == BLK_N + 1));

  assert_no_result_in_stall_R3: assert property (@(posedge clk) disable iff (rst)
    !pixReady |-> !resValid);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (int'(actOut) <= BLK_N * ((1 << PIX_W) - 1)));

  assert_mode_rule_R6: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (intraMode == (int'(actOut) < int'(sadCap) - BIAS)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    doneP |-> (resValid && $rose(resValid)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (resValid && !take) |=> (resValid && $stable(actOut) && $stable(meanOut) && $stable(intraMode)));

  assert_pixdata_known_R2: assert property (@(posedge clk) disable iff (rst)
    take |-> !$isunknown(pixData));

endmodule

bind mode_decider mode_decider_checker #(
  .PIX_W(PIX_W), .BLK_N(BLK_N), .SUM_W(SUM_W), .SAD_W(SAD_W), .BIAS(BIAS)
) chk (
  .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady),
  .pixData(pixData), .sadIn(sadIn), .resValid(resValid), .doneP(doneP),
  .intraMode(intraMode), .meanOut(meanOut), .actOut(actOut)
);

// File: tb/mode_decider_test.sv
module mode_decider_test;

  localparam int N = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixValid = 1'b0;
  logic [7:0] pixData = '0;
  logic [15:0] sadIn = '0;
  logic pixReady, resValid, doneP, intraMode;
  logic [7:0] meanOut;
  logic [15:0] actOut;

  int nChecks = 0;
  int nFail = 0;
  bit running = 0;

  always #5 clk = ~clk;

  mode_decider uut (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady),
    .pixData(pixData), .sadIn(sadIn), .resValid(resValid), .doneP(doneP),
    .intraMode(intraMode), .meanOut(meanOut), .actOut(actOut)
  );

  task automatic chk(bit ok, string req, string what, int actual, int expected);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // behavioural reference model: 0 load, 1 deviation pass, 2 decide, 3 show
  int mPhase = 0, mCnt = 0, mSad = 0, mMean = 0, mAct = 0;
  bit mValid = 0, mDone = 0, mIntra = 0;
  int q[$];

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mCnt = 0; mValid = 0; mDone = 0; q.delete();
    end else begin
      mDone = 0;
      case (mPhase)
        0, 3: if (pixValid) begin
          if (mCnt == 0) begin q.delete(); mSad = int'(sadIn); end
          mValid = 0;
          q.push_back(int'(pixData));
          mCnt++;
          if (mCnt == N) begin mCnt = 0; mPhase = 1; end else mPhase = 0;
        end
        1: begin
          mCnt++;
          if (mCnt == N) begin mCnt = 0; mPhase = 2; end
        end
        default: begin
          int s;
          s = 0;
          foreach (q[k]) s += q[k];
          mMean = s / N;
          mAct = 0;
          foreach (q[k]) mAct += (q[k] >= mMean) ? q[k] - mMean : mMean - q[k];
          mIntra = (mAct < mSad - 500);
          mValid = 1; mDone = 1; mPhase = 3;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      bit expReady;
      expReady = (mPhase == 0) || (mPhase == 3);
      chk(pixReady == expReady, "R2/R3/R9", "pixReady", int'(pixReady), int'(expReady));
      chk(resValid == mValid, "R8", "resValid", int'(resValid), int'(mValid));
      chk(doneP == mDone, "R7", "doneP", int'(doneP), int'(mDone));
      if (mValid) begin
        chk(int'(meanOut) == mMean, "R4", "meanOut", int'(meanOut), mMean);
        chk(int'(actOut) == mAct, "R5", "actOut", int'(actOut), mAct);
        chk(intraMode == mIntra, "R6", "intraMode", int'(intraMode), int'(mIntra));
      end
    end
  end

  function automatic logic [7:0] pixOf(int kind, int i);
    case (kind)
      0: return 8'd100;
      1: return 8'(i);
      2: return ((i % 2) ^ ((i / 16) % 2)) ? 8'd255 : 8'd0;
      3: return 8'($urandom);
      4: return 8'd255;
      default: return 8'd0;
    endcase
  endfunction

  task automatic sendBlock(int kind, int sad, bit gaps, bit noisy);
    for (int i = 0; i < N; i++) begin
      bit taken;
      taken = 0;
      while (!taken) begin
        @(negedge clk);
        if (gaps && ($urandom % 3 == 0)) begin
          pixValid = 1'b0;
          pixData  = 8'($urandom);
          sadIn    = 16'($urandom);
        end else begin
          pixValid = 1'b1;
          pixData  = pixOf(kind, i);
          sadIn    = (i == 0) ? 16'(sad) : 16'($urandom);
          taken    = pixReady;
        end
      end
    end
    do begin
      @(negedge clk);
      if (resValid) pixValid = 1'b0;
      else begin
        pixValid = noisy;   // R9: offered data during the stall must be ignored
        pixData  = 8'($urandom);
        sadIn    = 16'($urandom);
      end
    end while (!resValid);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pixReady == 1'b1, "R1", "pixReady in reset", int'(pixReady), 1);
    chk(resValid == 1'b0, "R1", "resValid in reset", int'(resValid), 0);
    chk(doneP == 1'b0, "R1", "doneP in reset", int'(doneP), 0);
    rst = 1'b0;
    running = 1;

    sendBlock(0, 600, 0, 0);
    chk(int'(actOut) == 0, "R5", "flat act", int'(actOut), 0);
    chk(int'(meanOut) == 100, "R4", "flat mean", int'(meanOut), 100);
    chk(intraMode == 1'b1, "R6", "flat sad600 intra", int'(intraMode), 1);

    sendBlock(0, 500, 0, 1);
    chk(intraMode == 1'b0, "R6", "act equals sad-bias gives inter", int'(intraMode), 0);

    sendBlock(1, 16885, 1, 0);
    chk(int'(meanOut) == 127, "R4", "ramp mean", int'(meanOut), 127);
    chk(int'(actOut) == 16384, "R5", "ramp act", int'(actOut), 16384);
    chk(intraMode == 1'b1, "R6", "ramp just below", int'(intraMode), 1);

    sendBlock(1, 16884, 0, 1);
    chk(intraMode == 1'b0, "R6", "ramp equality inter", int'(intraMode), 0);

    sendBlock(2, 100, 1, 1);
    chk(int'(meanOut) == 127, "R4", "checker mean", int'(meanOut), 127);
    chk(int'(actOut) == 32640, "R5", "checker act", int'(actOut), 32640);
    chk(intraMode == 1'b0, "R6", "sad below bias inter", int'(intraMode), 0);

    sendBlock(3, 20000, 1, 1);
    sendBlock(4, 65535, 0, 0);
    chk(int'(meanOut) == 255, "R4", "saturated mean", int'(meanOut), 255);
    chk(intraMode == 1'b1, "R6", "saturated intra", int'(intraMode), 1);

    sendBlock(5, 0, 0, 1);
    chk(int'(actOut) == 0 && intraMode == 1'b0, "R6", "zero block sad0", int'(intraMode), 0);

    // R8: results hold while idle and drop after a new first pixel
    repeat (5) @(negedge clk);
    chk(resValid == 1'b1, "R8", "held while idle", int'(resValid), 1);

    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog run did not end actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule